// File: doc/BRIEF.md
# I2C Event Flag and Line Status Register

This block is the status side of an I2C controller as seen by software. It holds eight event flags raised by single-cycle pulses from the protocol engine. Next to them, in the same 16-bit read word, it shows the live condition of the bus: both line levels, the busy indicator and the transfer direction. The protocol engine itself is outside the block. It supplies the event pulses, the busy and direction levels and the raw line inputs.

Event flags are cleared in one of three ways, fixed per flag. The six protocol-event flags clear when software writes a one to their bit. The receive-buffer-full flag clears as a side effect of software reading the receive data register. The transmit-buffer-empty flag clears as a side effect of software writing the transmit data register. The bus decoder signals those two accesses to this block with strobes.

A separate 8-bit enable word masks the flags. A registered interrupt line goes high when any enabled flag is set. A software reset input clears the flags, the busy bit and the interrupt. It leaves the line levels, the direction bit and the enable word unchanged. A hardware reset returns everything to zero.

Top module: `i2c_flag_status`

## Requirements
- R1: Bits 15, 14, 13 and 8 of `stat_rdata` always read 0. Writing ones to them through `stat_wr` has no effect.
- R2: Bit 12 reads 1 when SDA is low, and bit 11 reads 1 when SCL is low. Each line passes through a two-flop synchronizer, so the bit shows the line value sampled two clock edges earlier. After hardware reset both bits read 0.
- R3: Bit 10 reads 1 when the bus is busy. Bit 9 reads 1 for transmit and 0 for receive. Each bit shows its input as registered at the previous clock edge.
- R4: Bits 7 to 2 hold, from high to low: byte-end, general-call, NACK, STOP, START and error. A pulse on `evt_set[i]` sets flag i on the next edge. A `stat_wr` with `wdata[i]`=1 clears flag i (i in 7..2). A 0 in that position leaves the flag unchanged.
- R5: Bit 1 (receive buffer full) is set by `evt_set[1]` and cleared only by `rxd_rd`. Writes through `stat_wr` have no effect on it.
- R6: Bit 0 (transmit buffer empty) is set by `evt_set[0]` and cleared only by `txd_wr`. Writes through `stat_wr` have no effect on it.
- R7: When a set pulse and any clear of the same flag arrive in the same cycle, the flag ends up set.
- R8: `ien_wr` loads `wdata[7:0]` into the enable word, which reads back on `ien_rdata`. Enable bit i masks flag i.
- R9: `irq` is 1 in the cycle after some flag i and enable bit i were both 1, and 0 otherwise.
- R10: A `soft_rst` pulse clears all eight flags, the busy bit and `irq` on the next edge, and it overrides set pulses. It does not change bits 12, 11, 9 or the enable word.
- R11: Under hardware reset (`rst_n`=0), `stat_rdata`, `ien_rdata` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| soft_rst | input | 1 | Software reset pulse |
| stat_wr | input | 1 | Write strobe for the status/flag register |
| ien_wr | input | 1 | Write strobe for the enable register |
| wdata | input | 16 | Write data for both registers |
| rxd_rd | input | 1 | Strobe: software read of the receive data register |
| txd_wr | input | 1 | Strobe: software write of the transmit data register |
| evt_set | input | 8 | Event set pulses, one per flag position |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| bus_busy | input | 1 | Bus busy level from the protocol engine |
| xmit_mode | input | 1 | 1 for transmit direction, 0 for receive |
| stat_rdata | output | 16 | Status and flag read word |
| ien_rdata | output | 8 | Enable register read word |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a collision on one flag in a single cycle. The set pulse for that flag has to coincide with every form of clear: a one in the write word, a receive-data read and a transmit-data write. A software reset then has to be shown to override that same set. The stimulus drives all set pulses together with all three clear strobes in one cycle and checks that all eight flags read back as set. It then repeats the collision with `soft_rst` asserted and expects all flags cleared. A long random phase afterwards mixes sparse pulses, writes and line toggles, and the behavioural model is compared against the design on every clock.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;

    localparam int REG_W       = 16;
    localparam int FLAG_W      = 8;
    localparam int BIT_SDA_LOW = 12;
    localparam int BIT_SCL_LOW = 11;
    localparam int BIT_BUSY    = 10;
    localparam int BIT_DIR     = 9;
    localparam int BIT_RBF     = 1;
    localparam int BIT_TBE     = 0;

    typedef enum logic [1:0] {
        CLR_BY_W1      = 2'd0,
        CLR_BY_RXREAD  = 2'd1,
        CLR_BY_TXWRITE = 2'd2
    } clr_kind_e;

    function automatic clr_kind_e clr_kind_of(input int idx);
        if (idx == BIT_RBF) return CLR_BY_RXREAD;
        if (idx == BIT_TBE) return CLR_BY_TXWRITE;
        return CLR_BY_W1;
    endfunction

    typedef struct packed {
        logic busy;
        logic dir;
    } live_stat_t;

    typedef struct packed {
        logic [FLAG_W-1:0] en;
        logic              irq;
    } irq_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_event_flags.sv
module i2c_event_flags
    import i2c_flag_pkg::*;
#(
    parameter int W = FLAG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] set_pulse,
    input  logic         w1c_wr,
    input  logic [W-1:0] w1c_mask,
    input  logic         rx_read,
    input  logic         tx_write,
    output logic [W-1:0] flags
);
    logic [W-1:0] clr_vec;
    logic [W-1:0] flags_d;
    logic [W-1:0] flags_q;

    for (genvar i = 0; i < W; i++) begin : g_clr
        if (clr_kind_of(i) == CLR_BY_RXREAD) begin : g_rx
            assign clr_vec[i] = rx_read;
        end else if (clr_kind_of(i) == CLR_BY_TXWRITE) begin : g_tx
            assign clr_vec[i] = tx_write;
        end else begin : g_w1
            assign clr_vec[i] = w1c_wr & w1c_mask[i];
        end
    end

    always_comb begin
        if (soft_rst) flags_d = '0;
        else          flags_d = set_pulse | (flags_q & ~clr_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/i2c_irq_gate.sv
module i2c_irq_gate
    import i2c_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              en_wr,
    input  logic [FLAG_W-1:0] en_wdata,
    input  logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] en,
    output logic              irq
);
    irq_state_t st_d;
    irq_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) st_d.en = en_wdata;
        st_d.irq = soft_rst ? 1'b0 : |(flags & st_q.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en  = st_q.en;
    assign irq = st_q.irq;
endmodule

// File: rtl/i2c_flag_status.sv
module i2c_flag_status
    import i2c_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              stat_wr,
    input  logic              ien_wr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              rxd_rd,
    input  logic              txd_wr,
    input  logic [FLAG_W-1:0] evt_set,
    input  logic              sda_in,
    input  logic              scl_in,
    input  logic              bus_busy,
    input  logic              xmit_mode,
    output logic [REG_W-1:0]  stat_rdata,
    output logic [FLAG_W-1:0] ien_rdata,
    output logic              irq
);
    logic              sda_sync;
    logic              scl_sync;
    logic [FLAG_W-1:0] flags;
    live_stat_t        live_d;
    live_stat_t        live_q;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_sync)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_sync)
    );

    i2c_event_flags #(.W(FLAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .set_pulse(evt_set), .w1c_wr(stat_wr), .w1c_mask(wdata[FLAG_W-1:0]),
        .rx_read(rxd_rd), .tx_write(txd_wr), .flags(flags)
    );

    i2c_irq_gate u_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .en_wr(ien_wr), .en_wdata(wdata[FLAG_W-1:0]), .flags(flags),
        .en(ien_rdata), .irq(irq)
    );

    always_comb begin
        live_d.busy = soft_rst ? 1'b0 : bus_busy;
        live_d.dir  = xmit_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live_d;
    end

    always_comb begin
        stat_rdata                 = '0;
        stat_rdata[FLAG_W-1:0]     = flags;
        stat_rdata[BIT_SDA_LOW]    = ~sda_sync;
        stat_rdata[BIT_SCL_LOW]    = ~scl_sync;
        stat_rdata[BIT_BUSY]       = live_q.busy;
        stat_rdata[BIT_DIR]        = live_q.dir;
    end
endmodule

// File: rtl/i2c_flag_status_chk.sv
module i2c_flag_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        stat_wr,
    input logic        rxd_rd,
    input logic        txd_wr,
    input logic [15:0] wdata,
    input logic [7:0]  evt_set,
    input logic        sda_in,
    input logic        scl_in,
    input logic [15:0] stat_rdata,
    input logic [7:0]  ien_rdata,
    input logic        irq
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_line_levels_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (stat_rdata[12] == !$past(sda_in, 2) &&
                                 stat_rdata[11] == !$past(scl_in, 2)));

    assert_w1c_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !soft_rst) |=>
        ((stat_rdata[7:2] & $past(wdata[7:2] & ~evt_set[7:2])) == 6'd0));

    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rxd_rd && !evt_set[1]) |=> !stat_rdata[1]);

    assert_rx_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[1] && !rxd_rd && !soft_rst) |=> stat_rdata[1]);

    assert_tx_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txd_wr && !evt_set[0]) |=> !stat_rdata[0]);

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_rst && evt_set != 8'd0) |=>
        ((stat_rdata[7:0] & $past(evt_set)) == $past(evt_set)));

    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_rst |=> (irq == $past(|(stat_rdata[7:0] & ien_rdata))));

    assert_soft_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (stat_rdata[7:0] == 8'd0 && !stat_rdata[10] && !irq));
endmodule

bind i2c_flag_status i2c_flag_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stat_wr(stat_wr),
    .rxd_rd(rxd_rd), .txd_wr(txd_wr), .wdata(wdata), .evt_set(evt_set),
    .sda_in(sda_in), .scl_in(scl_in), .stat_rdata(stat_rdata),
    .ien_rdata(ien_rdata), .irq(irq)
);

// File: tb/sim_i2c_flag_status.sv
`timescale 1ns/1ps
module sim_i2c_flag_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        stat_wr = 1'b0;
    logic        ien_wr = 1'b0;
    logic [15:0] wdata = 16'h0;
    logic        rxd_rd = 1'b0;
    logic        txd_wr = 1'b0;
    logic [7:0]  evt_set = 8'h0;
    logic        sda_in = 1'b1;
    logic        scl_in = 1'b1;
    logic        bus_busy = 1'b0;
    logic        xmit_mode = 1'b0;
    logic [15:0] stat_rdata;
    logic [7:0]  ien_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string ctx = "R11";

    // behavioural reference state
    bit [7:0] m_flags, m_en;
    bit       m_irq, m_busy, m_dir;
    bit       sda_hist[$];
    bit       scl_hist[$];

    always #2 clk = ~clk;

    i2c_flag_status u0 (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stat_wr(stat_wr),
        .ien_wr(ien_wr), .wdata(wdata), .rxd_rd(rxd_rd), .txd_wr(txd_wr),
        .evt_set(evt_set), .sda_in(sda_in), .scl_in(scl_in),
        .bus_busy(bus_busy), .xmit_mode(xmit_mode),
        .stat_rdata(stat_rdata), .ien_rdata(ien_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        bit [7:0] clr;
        if (!rst_n) begin
            m_flags = 0; m_en = 0; m_irq = 0; m_busy = 0; m_dir = 0;
            sda_hist = '{1'b1, 1'b1};
            scl_hist = '{1'b1, 1'b1};
        end else begin
            m_irq = soft_rst ? 1'b0 : ((m_flags & m_en) != 0);
            clr = 8'h0;
            if (stat_wr) clr = clr | (wdata[7:0] & 8'hFC);
            if (rxd_rd)  clr = clr | 8'h02;
            if (txd_wr)  clr = clr | 8'h01;
            m_flags = soft_rst ? 8'h0 : (evt_set | (m_flags & ~clr));
            if (ien_wr) m_en = wdata[7:0];
            m_busy = soft_rst ? 1'b0 : bus_busy;
            m_dir  = xmit_mode;
            sda_hist.push_back(sda_in); void'(sda_hist.pop_front());
            scl_hist.push_back(scl_in); void'(scl_hist.pop_front());
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%0h expected=%0h at %0t", req, ctx, act, exp, $time);
        end
    endtask

    task automatic compare();
        if (!rst_n) begin
            chk("R11", stat_rdata, 0);
            chk("R11", ien_rdata, 0);
            chk("R11", irq, 0);
            return;
        end
        chk("R1", {stat_rdata[15:13], stat_rdata[8]}, 0);
        chk("R2", stat_rdata[12], !sda_hist[0]);
        chk("R2", stat_rdata[11], !scl_hist[0]);
        chk("R3", stat_rdata[10], m_busy);
        chk("R3", stat_rdata[9], m_dir);
        chk("R4", stat_rdata[7:2], m_flags[7:2]);
        chk("R5", stat_rdata[1], m_flags[1]);
        chk("R6", stat_rdata[0], m_flags[0]);
        chk("R8", ien_rdata, m_en);
        chk("R9", irq, m_irq);
    endtask

    task automatic step();
        @(negedge clk);
        compare();
        soft_rst = 0; stat_wr = 0; ien_wr = 0; rxd_rd = 0; txd_wr = 0; evt_set = 0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        ctx = "R11";
        for (int i = 0; i < 4; i++) step();
        rst_n = 1;
        step(); step();

        ctx = "R8";
        ien_wr = 1; wdata = 16'h00A5; step(); step();
        ien_wr = 1; wdata = 16'h00FF; step(); step();

        ctx = "R4";
        for (int i = 0; i < 8; i++) begin
            evt_set = 8'(1 << i); step(); step();
        end
        stat_wr = 1; wdata = 16'h0000; step(); step();
        stat_wr = 1; wdata = 16'h00FF; step(); step();

        ctx = "R5";
        rxd_rd = 1; step(); step();
        ctx = "R6";
        txd_wr = 1; step(); step();

        ctx = "R7";
        evt_set = 8'hFF; stat_wr = 1; wdata = 16'hFFFF; rxd_rd = 1; txd_wr = 1;
        step(); step();

        ctx = "R1";
        stat_wr = 1; wdata = 16'hE100; step(); step();

        ctx = "R2";
        sda_in = 0; step(); step(); step();
        scl_in = 0; step(); step(); step();
        sda_in = 1; scl_in = 1; step(); step(); step();

        ctx = "R3";
        bus_busy = 1; xmit_mode = 1; step(); step();

        ctx = "R10";
        sda_in = 0; evt_set = 8'hFF; step(); step(); step();
        soft_rst = 1; evt_set = 8'h3C; step();
        bus_busy = 0; step(); step();
        ctx = "R9";
        ien_wr = 1; wdata = 16'h0004; step();
        evt_set = 8'h08; step(); step(); step();
        evt_set = 8'h04; step(); step(); step();

        ctx = "RND";
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 3) == 0) evt_set = 8'($urandom);
            if ($urandom_range(0, 4) == 0) begin stat_wr = 1; wdata = 16'($urandom); end
            else if ($urandom_range(0, 9) == 0) begin ien_wr = 1; wdata = 16'($urandom); end
            if ($urandom_range(0, 5) == 0) rxd_rd = 1;
            if ($urandom_range(0, 5) == 0) txd_wr = 1;
            if ($urandom_range(0, 60) == 0) soft_rst = 1;
            if ($urandom_range(0, 7) == 0) sda_in = ~sda_in;
            if ($urandom_range(0, 7) == 0) scl_in = ~scl_in;
            if ($urandom_range(0, 15) == 0) bus_busy = ~bus_busy;
            if ($urandom_range(0, 15) == 0) xmit_mode = ~xmit_mode;
            step();
            if (n == 2000) begin
                ctx = "R11";
                rst_n = 0; step(); step(); step();
                rst_n = 1; ctx = "RND";
            end
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule